// File: doc/BRIEF.md
# Word Rotate-and-Mask Execution Unit

This unit computes the result of a small group of 32-bit integer instructions that rotate a source word left and then keep only the bits selected by a mask. The mask is given by two 5-bit indices, a start and a stop position, both counted from the most-significant bit (bit 0 is the MSB). When the stop index is below the start index, the run of ones wraps around both ends of the word. One datapath serves three operations. Two of them rotate and then clear every bit outside the mask: one takes the rotate amount from an immediate field, the other from the low five bits of a second register value. The third rotates by the immediate and inserts the masked bits into the old destination value.

The decode stage gives the unit the primary opcode, the operand values and the mask fields. The unit returns the new destination value with its write strobe. When the record bit is set it also returns a 4-bit condition field with its own strobe. The outputs can be registered (the default) or combinational.

Top module: `rotmask_unit`

## Requirements
- R1: The rotate is a left rotate by the low 5 bits of the selected amount, taken modulo 32. An amount of 0 passes the source word through unchanged.
- R2: When the stop index is at or above the start index, the mask has ones exactly at MSB-numbered positions start through stop, which are little-endian bits 31-start down to 31-stop.
- R3: When the stop index is below the start index, the mask is all ones except MSB-numbered positions stop+1 through start-1. If start equals stop+1, the mask is all ones.
- R4: Opcode 21 gives result = rotl(src_s, sh_imm) & mask.
- R5: Opcode 23 gives result = rotl(src_s, src_b[4:0]) & mask. Bits src_b[31:5] have no effect.
- R6: Opcode 20 gives result = (rotl(src_s, sh_imm) & mask) | (old_a & ~mask).
- R7: wr_en is 1 only for opcodes 20, 21 and 23. For any other opcode, wr_en, cr_en, result and cr_field are all 0.
- R8: cr_en equals wr_en & rec_bit. cr_field is {LT, GT, EQ, SO} (bit 3 down to bit 0), with LT, GT and EQ comparing the result, read as a signed value, against zero. cr_field is 0 when cr_en is 0.
- R9: The SO bit of cr_field (bit 0) copies xer_so whenever cr_en is 1.
- R10: With REG_OUT=1, the outputs take on a new input set at the rising clock edge that follows it. While rst_n is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 6 | Primary opcode |
| src_s | input | 32 | Word to rotate |
| old_a | input | 32 | Old destination value, used by the insert form |
| src_b | input | 32 | Register holding the rotate amount |
| sh_imm | input | 5 | Immediate rotate amount |
| mbeg | input | 5 | Mask start index (MSB = 0) |
| mend | input | 5 | Mask stop index (MSB = 0) |
| rec_bit | input | 1 | Request a condition-field update |
| xer_so | input | 1 | Summary-overflow bit to copy |
| result | output | 32 | New destination value |
| wr_en | output | 1 | Destination write strobe |
| cr_field | output | 4 | Condition field {LT,GT,EQ,SO} |
| cr_en | output | 1 | Condition field write strobe |

## Verification
If the mask generator went wrong on a wrapped or boundary index pair, the error would reach the port one cycle later, as flipped result bits at the wrap edges. In the insert form it would show as old_a bits that were not kept. A fault in the rotator shows up as result bits that are displaced by a constant distance, and it shows most clearly at amounts 0 and 31. A decode fault shows at once as a write strobe on an unused opcode, or as a condition field whose compare bits are not one-hot.

// File: rtl/rm_pkg.sv
package rm_pkg;
  localparam logic [5:0] OPC_INSERT  = 6'd20;
  localparam logic [5:0] OPC_AND_IMM = 6'd21;
  localparam logic [5:0] OPC_AND_REG = 6'd23;

  typedef enum logic [1:0] {
    K_NONE    = 2'd0,
    K_AND_IMM = 2'd1,
    K_AND_REG = 2'd2,
    K_INSERT  = 2'd3
  } op_kind_t;

  function automatic op_kind_t decode_kind(input logic [5:0] opc);
    case (opc)
      OPC_AND_IMM: decode_kind = K_AND_IMM;
      OPC_AND_REG: decode_kind = K_AND_REG;
      OPC_INSERT:  decode_kind = K_INSERT;
      default:     decode_kind = K_NONE;
    endcase
  endfunction
endpackage

// File: rtl/rm_rotator.sv
module rm_rotator #(
  parameter int W = 32,
  localparam int SHW = $clog2(W)
) (
  input  logic [W-1:0]   din,
  input  logic [SHW-1:0] amt,
  output logic [W-1:0]   dout
);
  function automatic logic [W-1:0] rotl(input logic [W-1:0] x, input logic [SHW-1:0] n);
    logic [2*W-1:0] dbl;
    dbl  = {x, x} << n;
    rotl = dbl[2*W-1:W];
  endfunction

  assign dout = rotl(din, amt);
endmodule

// File: rtl/rm_mask_gen.sv
module rm_mask_gen #(
  parameter int W = 32,
  localparam int SHW = $clog2(W)
) (
  input  logic [SHW-1:0] first_idx,
  input  logic [SHW-1:0] last_idx,
  output logic [W-1:0]   mask
);
  logic wraps;
  assign wraps = last_idx < first_idx;

  always_comb begin
    for (int j = 0; j < W; j++) begin
      logic [SHW-1:0] be;
      logic ge_first, le_last;
      be       = SHW'(W - 1 - j);
      ge_first = be >= first_idx;
      le_last  = be <= last_idx;
      mask[j]  = wraps ? (ge_first | le_last) : (ge_first & le_last);
    end
  end
endmodule

// File: rtl/rm_cr_eval.sv
module rm_cr_eval #(
  parameter int W = 32
) (
  input  logic [W-1:0] res,
  input  logic         so_in,
  input  logic         enable,
  output logic [3:0]   cr
);
  logic is_neg, is_zero;
  assign is_neg  = res[W-1];
  assign is_zero = (res == '0);
  assign cr = enable ? {is_neg, ~is_neg & ~is_zero, is_zero, so_in} : 4'b0000;
endmodule

// File: rtl/rotmask_unit.sv
module rotmask_unit #(
  parameter int W = 32,
  parameter bit REG_OUT = 1'b1,
  localparam int SHW = $clog2(W)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [5:0]     opcode,
  input  logic [W-1:0]   src_s,
  input  logic [W-1:0]   old_a,
  input  logic [W-1:0]   src_b,
  input  logic [SHW-1:0] sh_imm,
  input  logic [SHW-1:0] mbeg,
  input  logic [SHW-1:0] mend,
  input  logic           rec_bit,
  input  logic           xer_so,
  output logic [W-1:0]   result,
  output logic           wr_en,
  output logic [3:0]     cr_field,
  output logic           cr_en
);
  import rm_pkg::*;

  op_kind_t       kind;
  logic [SHW-1:0] rot_amt;
  logic [W-1:0]   rot_w, mask_w, comb_res;
  logic           comb_wr, comb_cr_en;
  logic [3:0]     comb_cr;

  assign kind    = decode_kind(opcode);
  assign rot_amt = (kind == K_AND_REG) ? src_b[SHW-1:0] : sh_imm;

  rm_rotator #(.W(W)) u_rot (.din(src_s), .amt(rot_amt), .dout(rot_w));
  rm_mask_gen #(.W(W)) u_mask (.first_idx(mbeg), .last_idx(mend), .mask(mask_w));

  always_comb begin
    unique case (kind)
      K_AND_IMM, K_AND_REG: comb_res = rot_w & mask_w;
      K_INSERT:             comb_res = (rot_w & mask_w) | (old_a & ~mask_w);
      default:              comb_res = '0;
    endcase
  end

  assign comb_wr    = (kind != K_NONE);
  assign comb_cr_en = comb_wr & rec_bit;

  rm_cr_eval #(.W(W)) u_cr (.res(comb_res), .so_in(xer_so), .enable(comb_cr_en), .cr(comb_cr));

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          result   <= '0;
          wr_en    <= 1'b0;
          cr_field <= 4'b0000;
          cr_en    <= 1'b0;
        end else begin
          result   <= comb_res;
          wr_en    <= comb_wr;
          cr_field <= comb_cr;
          cr_en    <= comb_cr_en;
        end
      end
    end else begin : g_comb
      assign result   = comb_res;
      assign wr_en    = comb_wr;
      assign cr_field = comb_cr;
      assign cr_en    = comb_cr_en;
    end
  endgenerate
endmodule

// File: rtl/rm_checks.sv
module rm_checks #(
  parameter int W = 32,
  localparam int SHW = $clog2(W)
) (
  input logic           clk,
  input logic           rst_n,
  input logic [5:0]     opcode,
  input logic [W-1:0]   src_s,
  input logic [W-1:0]   old_a,
  input logic           rec_bit,
  input logic           xer_so,
  input logic [SHW-1:0] rot_amt,
  input logic [W-1:0]   rot_w,
  input logic [W-1:0]   mask_w,
  input logic [W-1:0]   comb_res,
  input logic           comb_wr,
  input logic           comb_cr_en,
  input logic [3:0]     comb_cr
);
  logic is_and, is_ins, is_valid;
  assign is_and   = (opcode == 6'd21) || (opcode == 6'd23);
  assign is_ins   = (opcode == 6'd20);
  assign is_valid = is_and || is_ins;

  p_zero_rot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rot_amt == '0) |-> (rot_w == src_s));

  p_mask_nonempty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mask_w != '0);

  p_and_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    is_and |-> ((comb_res & ~mask_w) == '0));

  p_insert_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    is_ins |-> (((comb_res ^ old_a) & ~mask_w) == '0));

  p_invalid_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !is_valid |-> (!comb_wr && !comb_cr_en && comb_res == '0));

  p_cr_needs_rec_r8: assert property (@(posedge clk) disable iff (!rst_n)
    comb_cr_en |-> (comb_wr && rec_bit));

  p_cr_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    comb_cr_en |-> ($countones(comb_cr[3:1]) == 1));

  p_so_copy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    comb_cr_en |-> (comb_cr[0] == xer_so));
endmodule

bind rotmask_unit rm_checks #(.W(W)) u_checks (
  .clk(clk), .rst_n(rst_n), .opcode(opcode), .src_s(src_s), .old_a(old_a),
  .rec_bit(rec_bit), .xer_so(xer_so), .rot_amt(rot_amt), .rot_w(rot_w),
  .mask_w(mask_w), .comb_res(comb_res), .comb_wr(comb_wr),
  .comb_cr_en(comb_cr_en), .comb_cr(comb_cr)
);

// File: tb/sim_rotmask_unit.sv
module sim_rotmask_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  opcode = '0;
  logic [31:0] src_s = '0, old_a = '0, src_b = '0;
  logic [4:0]  sh_imm = '0, mbeg = '0, mend = '0;
  logic        rec_bit = 1'b0, xer_so = 1'b0;
  logic [31:0] result;
  logic        wr_en, cr_en;
  logic [3:0]  cr_field;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rotmask_unit u0 (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .src_s(src_s), .old_a(old_a),
    .src_b(src_b), .sh_imm(sh_imm), .mbeg(mbeg), .mend(mend),
    .rec_bit(rec_bit), .xer_so(xer_so), .result(result), .wr_en(wr_en),
    .cr_field(cr_field), .cr_en(cr_en)
  );

  function automatic logic [31:0] ref_mask(input int b, input int e);
    logic [31:0] ones;
    ones = 32'hFFFF_FFFF;
    if (e >= b) ref_mask = (ones >> b) & (ones << (31 - e));
    else        ref_mask = ~((ones >> (e + 1)) & (ones << (31 - (b - 1))));
  endfunction

  function automatic logic [31:0] ref_rot(input logic [31:0] x, input int n);
    if (n == 0) ref_rot = x;
    else        ref_rot = (x << n) | (x >> (32 - n));
  endfunction

  task automatic expect_out(input string tag, input logic [31:0] er, input logic ew,
                            input logic [3:0] ec, input logic ece);
    checks++;
    if (result !== er || wr_en !== ew || cr_field !== ec || cr_en !== ece) begin
      errors++;
      $display("FAIL %s: got res=%h wr=%b cr=%b cre=%b, expected res=%h wr=%b cr=%b cre=%b",
               tag, result, wr_en, cr_field, cr_en, er, ew, ec, ece);
    end
  endtask

  task automatic run_vec(input string tag, input logic [5:0] op, input logic [31:0] s,
                         input logic [31:0] a, input logic [31:0] b, input int sh,
                         input int mb, input int me, input logic rc, input logic so);
    logic [31:0] m, r, er;
    logic ew, ece;
    logic [3:0] ec;
    @(negedge clk);
    opcode = op; src_s = s; old_a = a; src_b = b; sh_imm = 5'(sh);
    mbeg = 5'(mb); mend = 5'(me); rec_bit = rc; xer_so = so;
    m = ref_mask(mb, me);
    ew = 1'b1;
    case (op)
      6'd21: er = ref_rot(s, sh) & m;
      6'd23: er = ref_rot(s, int'(b % 32)) & m;
      6'd20: er = (ref_rot(s, sh) & m) | (a & ~m);
      default: begin er = '0; ew = 1'b0; end
    endcase
    ece = ew & rc;
    r = er;
    if (!ece) ec = 4'b0000;
    else if ($signed(r) < 0) ec = {3'b100, so};
    else if (r == 0) ec = {3'b001, so};
    else ec = {3'b010, so};
    @(negedge clk);
    expect_out(tag, er, ew, ec, ece);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    opcode = 6'd21; src_s = 32'hFFFF_FFFF; rec_bit = 1'b1;
    repeat (3) @(negedge clk);
    expect_out("R10 reset", 32'h0, 1'b0, 4'b0000, 1'b0);
    rst_n = 1'b1;

    run_vec("R1 zero amount", 6'd21, 32'hDEAD_BEEF, 0, 0, 0, 0, 31, 0, 0);
    run_vec("R1 amount 31", 6'd21, 32'h8000_0001, 0, 0, 31, 0, 31, 0, 0);
    run_vec("R4 rotate 8", 6'd21, 32'h1234_5678, 0, 0, 8, 0, 31, 0, 0);
    run_vec("R2 contiguous", 6'd21, 32'hFFFF_FFFF, 0, 0, 0, 4, 11, 0, 0);
    run_vec("R2 single bit", 6'd21, 32'hFFFF_FFFF, 0, 0, 0, 31, 31, 0, 0);
    run_vec("R3 wrapped", 6'd21, 32'hFFFF_FFFF, 0, 0, 0, 28, 3, 0, 0);
    run_vec("R3 full wrap", 6'd21, 32'hA5A5_5A5A, 0, 0, 0, 10, 9, 0, 0);
    run_vec("R5 reg amount", 6'd23, 32'h0000_00F1, 0, 32'hFFFF_FFE5, 13, 0, 31, 0, 0);
    run_vec("R5 reg zero", 6'd23, 32'hCAFE_F00D, 0, 32'hFFFF_FFE0, 7, 0, 31, 0, 0);
    run_vec("R6 insert", 6'd20, 32'h0000_00AB, 32'h1111_1111, 0, 8, 16, 23, 0, 0);
    run_vec("R6 insert wrap", 6'd20, 32'hFFFF_FFFF, 32'h0, 0, 3, 30, 1, 0, 0);
    run_vec("R7 unused op", 6'd22, 32'hFFFF_FFFF, 0, 0, 0, 0, 31, 1, 1);
    run_vec("R7 op zero", 6'd0, 32'h1, 0, 0, 0, 0, 31, 1, 0);
    run_vec("R8 negative", 6'd21, 32'h8000_0000, 0, 0, 0, 0, 31, 1, 0);
    run_vec("R8 zero", 6'd21, 32'h0000_FFFF, 0, 0, 0, 0, 15, 1, 0);
    run_vec("R8 positive", 6'd23, 32'h1, 0, 32'h4, 0, 0, 31, 1, 0);
    run_vec("R9 so copy", 6'd20, 32'h0, 32'h0, 0, 0, 0, 31, 1, 1);

    // R10: output holds previous value until the next rising edge
    @(negedge clk);
    opcode = 6'd21; src_s = 32'h0000_00FF; sh_imm = 0; mbeg = 0; mend = 31; rec_bit = 0;
    #1;
    checks++;
    if (result !== 32'h0) begin
      errors++;
      $display("FAIL R10 latency: got res=%h, expected res=%h", result, 32'h0);
    end
    @(negedge clk);
    expect_out("R10 after edge", 32'h0000_00FF, 1'b1, 4'b0000, 1'b0);

    void'($urandom(32'd1234));
    for (int i = 0; i < 400; i++) begin
      logic [5:0] op;
      int sel;
      sel = int'($urandom % 8);
      op = (sel < 2) ? 6'd20 : (sel < 4) ? 6'd21 : (sel < 6) ? 6'd23 : 6'($urandom);
      run_vec("R4 random", op, $urandom, $urandom, $urandom, int'($urandom % 32),
              int'($urandom % 32), int'($urandom % 32), 1'($urandom), 1'($urandom));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule